// File: doc/BRIEF.md
# Interrupt Aggregator with Memory-Write Notification

This block collects level interrupt lines from on-chip devices and turns each newly raised, enabled line into one bus-master write transaction toward the processor. A single 32-bit address register supplies both the destination of that write (its upper 27 bits, with the low five forced to zero) and the data word (its low five bits, zero-extended). Software sees five registers on a small word-addressed port: a latched request register, a mask, a pending register that clears when it is touched, a control register holding a delivery-suppress bit, and the address register.

Inputs are edge-detected, so a line that stays high is counted once. Pending bits record every raised line, enabled or not. Request bits record only enabled ones and stay set until reset. Notifications are queued one at a time: one write can wait on the acknowledge, and one more can wait in a single slot behind it. A sticky output flags a mask value that sets lines which do not exist.

Top module: `irq_msg_aggregator`

## Requirements
- R1: A rising edge on `irq_in[i]` sets pending bit i in the following cycle whatever the mask holds; pending and request bits at or above NUM_IRQ always read zero.
- R2: A rising edge on an input whose mask bit is set also sets its request bit; request bits stay set until reset, and writes to the request register (offset 0x00) change nothing.
- R3: An enabled rising edge raises `msg_req` in the following cycle with `msg_addr` = address register with bits 4:0 cleared and `msg_data` = address bits 4:0 zero-extended, both taken when the edge is seen; `msg_req`, `msg_addr` and `msg_data` hold until the cycle in which `msg_ack` is high.
- R4: While control bit 0 (suppress, offset 0x0C) is 1, an enabled edge starts and queues no write; a control read returns bit 0 with bits 31:1 zero.
- R5: A read of pending (offset 0x08) returns its value and clears it; any write there clears it whatever the data or byte enables; an edge seen in the same cycle as the clear leaves its bit set.
- R6: After reset: request, mask, pending and control read zero, the address register (offset 0x10) reads 0xFFFB0003, `msg_req` and `mask_bad` are low.
- R7: Writes honour byte enables in big-endian lane order: `rb_be[3]` covers bits 31:24 (lowest byte address) down to `rb_be[0]` for bits 7:0; reads return the full word; offsets 0x14 to 0x1C read zero and writes there change nothing.
- R8: A mask write stores the merged value unchanged; `mask_bad` goes high the next cycle and stays high until reset if that value has any bit at or above NUM_IRQ set and is not all ones.
- R9: An enabled edge that arrives while a write waits for acknowledge is held in one slot and presented in the cycle after the acknowledge; further edges while the slot is occupied issue nothing.
- R10: An input held high sets its pending and request bits only once; after pending is cleared it stays clear until the line falls and rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_IRQ | Level interrupt lines, synchronous to clk |
| rb_addr | input | 5 | Register byte offset (bits 4:2 select the word) |
| rb_wr | input | 1 | Register write strobe |
| rb_rd | input | 1 | Register read strobe |
| rb_be | input | 4 | Write byte enables, bit 3 = bits 31:24 |
| rb_wdata | input | 32 | Write data |
| rb_rdata | output | 32 | Read data for the word at rb_addr |
| msg_req | output | 1 | Notification write request |
| msg_ack | input | 1 | Notification write accepted |
| msg_addr | output | 32 | Notification write address, 32-byte aligned |
| msg_data | output | 32 | Notification write data |
| mask_bad | output | 1 | Sticky flag for an out-of-range mask value |

## Verification
The pending register can be cleared by software and set by a new edge in the same cycle; the bench raises a line on exactly the cycle of a pending read and again on a pending write, and judges by the following read that the fresh bit survived while older ones vanished. The second collision is between an acknowledge and a new enabled edge while the slot is occupied or empty; the bench varies the acknowledge delay and spaces edges one cycle apart, and its reference queue decides on every clock which address must be on the master port.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int DW = 32;
    localparam int AW = 5;

    // Word indices (rb_addr[4:2])
    localparam logic [2:0] W_REQ  = 3'd0;
    localparam logic [2:0] W_MASK = 3'd1;
    localparam logic [2:0] W_PEND = 3'd2;
    localparam logic [2:0] W_CTRL = 3'd3;
    localparam logic [2:0] W_DEST = 3'd4;

    typedef struct packed {
        logic [DW-1:0] req;
        logic [DW-1:0] mask;
        logic [DW-1:0] pend;
        logic [DW-1:0] dest;
        logic          quiet;
        logic          mask_bad;
    } regs_t;

    // Byte-lane merge: lane i covers bits 8i+7..8i, lane 3 is the lowest byte address.
    function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_v,
                                                 input logic [DW-1:0] new_v,
                                                 input logic [3:0]    be);
        logic [DW-1:0] r;
        r = old_v;
        for (int i = 0; i < 4; i++) begin
            if (be[i]) r[8*i +: 8] = new_v[8*i +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/irqc_edge.sv
module irqc_edge #(
    parameter int N = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/irqc_msg_slot.sv
module irqc_msg_slot #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fire,
    input  logic [W-1:0] fire_val,
    input  logic         ack,
    output logic         busy,
    output logic [W-1:0] cur_val
);
    typedef struct packed {
        logic         busy;
        logic [W-1:0] cur;
        logic         slot_v;
        logic [W-1:0] slot;
    } q_t;

    q_t st_d, st_q;
    logic done;

    always_comb begin
        st_d = st_q;
        done = st_q.busy && ack;
        if (!st_q.busy) begin
            if (fire) begin
                st_d.busy = 1'b1;
                st_d.cur  = fire_val;
            end
        end else if (!done) begin
            if (fire && !st_q.slot_v) begin
                st_d.slot_v = 1'b1;
                st_d.slot   = fire_val;
            end
        end else if (st_q.slot_v) begin
            st_d.cur    = st_q.slot;
            st_d.slot_v = fire;
            if (fire) st_d.slot = fire_val;
        end else if (fire) begin
            st_d.cur = fire_val;
        end else begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign cur_val = st_q.cur;
endmodule

// File: rtl/irq_msg_aggregator.sv
module irq_msg_aggregator
    import irqc_pkg::*;
#(
    parameter int          NUM_IRQ    = 24,
    parameter logic [31:0] RESET_DEST = 32'hFFFB_0003
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic [4:0]         rb_addr,
    input  logic               rb_wr,
    input  logic               rb_rd,
    input  logic [3:0]         rb_be,
    input  logic [31:0]        rb_wdata,
    output logic [31:0]        rb_rdata,
    output logic               msg_req,
    input  logic               msg_ack,
    output logic [31:0]        msg_addr,
    output logic [31:0]        msg_data,
    output logic               mask_bad
);
    localparam logic [DW-1:0] IMPL = (32'h1 << NUM_IRQ) - 32'h1;

    regs_t st_d, st_q;
    logic [NUM_IRQ-1:0] irq_rise;
    logic [DW-1:0]      rise_w;
    logic [DW-1:0]      mask_new;
    logic [2:0]         widx;
    logic               fire;
    logic               q_busy;
    logic [DW-1:0]      q_val;

    irqc_edge #(.N(NUM_IRQ)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (irq_in),
        .rise (irq_rise)
    );

    always_comb begin
        rise_w = '0;
        rise_w[NUM_IRQ-1:0] = irq_rise;
    end

    assign widx = rb_addr[4:2];
    assign fire = (|(rise_w & st_q.mask)) && !st_q.quiet;

    irqc_msg_slot #(.W(DW)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .fire_val(st_q.dest),
        .ack     (msg_ack),
        .busy    (q_busy),
        .cur_val (q_val)
    );

    always_comb begin
        st_d     = st_q;
        mask_new = lane_merge(st_q.mask, rb_wdata, rb_be);

        st_d.req = st_q.req | (rise_w & st_q.mask);

        if ((rb_rd || rb_wr) && widx == W_PEND) st_d.pend = '0;
        st_d.pend = st_d.pend | rise_w;

        if (rb_wr) begin
            case (widx)
                W_MASK: begin
                    st_d.mask = mask_new;
                    if (((mask_new & ~IMPL) != '0) && (mask_new != '1))
                        st_d.mask_bad = 1'b1;
                end
                W_CTRL: if (rb_be[0]) st_d.quiet = rb_wdata[0];
                W_DEST: st_d.dest = lane_merge(st_q.dest, rb_wdata, rb_be);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.dest <= RESET_DEST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (widx)
            W_REQ:   rb_rdata = st_q.req;
            W_MASK:  rb_rdata = st_q.mask;
            W_PEND:  rb_rdata = st_q.pend;
            W_CTRL:  rb_rdata = {31'b0, st_q.quiet};
            W_DEST:  rb_rdata = st_q.dest;
            default: rb_rdata = '0;
        endcase
    end

    assign msg_req  = q_busy;
    assign msg_addr = {q_val[31:5], 5'b0};
    assign msg_data = {27'b0, q_val[4:0]};
    assign mask_bad = st_q.mask_bad;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int NUM_IRQ = 24
) (
    input logic        clk,
    input logic        rst_n,
    input logic        msg_req,
    input logic        msg_ack,
    input logic [31:0] msg_addr,
    input logic [31:0] msg_data,
    input logic        rb_rd,
    input logic [4:0]  rb_addr,
    input logic [31:0] rb_rdata,
    input logic [31:0] rise,
    input logic [31:0] pend,
    input logic [31:0] req,
    input logic        quiet
);
    localparam logic [31:0] IMPL = (32'h1 << NUM_IRQ) - 32'h1;

    assert_hold_until_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_req && !msg_ack) |=> (msg_req && $stable(msg_addr) && $stable(msg_data)));

    assert_msg_format_R3: assert property (@(posedge clk) disable iff (!rst_n)
        msg_req |-> (msg_addr[4:0] == 5'd0 && msg_data[31:5] == 27'd0));

    assert_pend_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_rd && rb_addr[4:2] == 3'd2 && rise == 32'd0) |=> (pend == 32'd0));

    assert_req_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((req & $past(req)) == $past(req)));

    assert_quiet_no_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!msg_req && quiet) |=> !msg_req);

    assert_ctrl_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_rd && rb_addr[4:2] == 3'd3) |-> (rb_rdata[31:1] == 31'd0));

    assert_pend_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~IMPL) == 32'd0));
endmodule

bind irq_msg_aggregator irqc_checker #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .msg_req (msg_req),
    .msg_ack (msg_ack),
    .msg_addr(msg_addr),
    .msg_data(msg_data),
    .rb_rd   (rb_rd),
    .rb_addr (rb_addr),
    .rb_rdata(rb_rdata),
    .rise    (rise_w),
    .pend    (st_q.pend),
    .req     (st_q.req),
    .quiet   (st_q.quiet)
);

// File: tb/irq_msg_aggregator_bench.sv
`timescale 1ns/1ps
module irq_msg_aggregator_bench;
    localparam int N = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_in = '0;
    logic [4:0]   rb_addr = '0;
    logic         rb_wr = 1'b0;
    logic         rb_rd = 1'b0;
    logic [3:0]   rb_be = '0;
    logic [31:0]  rb_wdata = '0;
    logic [31:0]  rb_rdata;
    logic         msg_req;
    logic         msg_ack = 1'b0;
    logic [31:0]  msg_addr;
    logic [31:0]  msg_data;
    logic         mask_bad;

    always #4 clk = ~clk;

    irq_msg_aggregator #(.NUM_IRQ(N)) u_irq_msg_aggregator (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .rb_addr(rb_addr), .rb_wr(rb_wr), .rb_rd(rb_rd), .rb_be(rb_be),
        .rb_wdata(rb_wdata), .rb_rdata(rb_rdata),
        .msg_req(msg_req), .msg_ack(msg_ack), .msg_addr(msg_addr),
        .msg_data(msg_data), .mask_bad(mask_bad)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string tag = "R6";
    bit    done = 1'b0;

    // ---------------- reference model ----------------
    logic [31:0] m_req, m_mask, m_pend, m_dest;
    logic        m_quiet, m_bad;
    logic [N-1:0] m_prev;
    logic [31:0] mq[$];

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                          input logic [3:0] be);
        logic [31:0] r = o;
        if (be[3]) r[31:24] = n[31:24];
        if (be[2]) r[23:16] = n[23:16];
        if (be[1]) r[15:8]  = n[15:8];
        if (be[0]) r[7:0]   = n[7:0];
        return r;
    endfunction

    function automatic logic [31:0] model_read(input logic [4:0] a);
        case (a)
            5'h00: return m_req;
            5'h04: return m_mask;
            5'h08: return m_pend;
            5'h0C: return {31'b0, m_quiet};
            5'h10: return m_dest;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_req = 0; m_mask = 0; m_pend = 0; m_dest = 32'hFFFB0003;
            m_quiet = 0; m_bad = 0; m_prev = '0; mq.delete();
        end else begin
            logic [31:0] r;
            logic [31:0] nv;
            logic        f;
            r = 32'(irq_in & ~m_prev);
            m_prev = irq_in;
            f = ((r & m_mask) != 0) && !m_quiet;
            if (mq.size() > 0 && msg_ack) void'(mq.pop_front());
            if (f && mq.size() < 2) mq.push_back(m_dest);
            m_req = m_req | (r & m_mask);
            if ((rb_rd || rb_wr) && rb_addr == 5'h08) m_pend = 0;
            m_pend = m_pend | r;
            if (rb_wr) begin
                case (rb_addr)
                    5'h04: begin
                        nv = merge(m_mask, rb_wdata, rb_be);
                        m_mask = nv;
                        if ((nv[31:N] != 0) && (nv != 32'hFFFFFFFF)) m_bad = 1;
                    end
                    5'h0C: if (rb_be[0]) m_quiet = rb_wdata[0];
                    5'h10: m_dest = merge(m_dest, rb_wdata, rb_be);
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string t, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
        end
    endtask

    // compare every cycle, well away from the rising edge
    always @(negedge clk) begin
        #3;
        if (rst_n && !done) begin
            check(tag, "msg_req", {31'b0, msg_req}, {31'b0, mq.size() > 0});
            if (msg_req && mq.size() > 0) begin
                check("R3", "msg_addr", msg_addr, {mq[0][31:5], 5'b0});
                check("R3", "msg_data", msg_data, {27'b0, mq[0][4:0]});
            end
            check("R8", "mask_bad", {31'b0, mask_bad}, {31'b0, m_bad});
            if (rb_rd) check(tag, "read", rb_rdata, model_read(rb_addr));
        end
    end

    // acknowledge responder
    int ack_delay = 1;
    int wait_cnt = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            msg_ack = 0; wait_cnt = 0;
        end else begin
            if (msg_ack) wait_cnt = 0;
            else if (msg_req) wait_cnt++;
            msg_ack = msg_req && (wait_cnt >= ack_delay);
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        rb_addr = a; rb_be = be; rb_wdata = d; rb_wr = 1;
        @(negedge clk);
        rb_wr = 0;
    endtask

    task automatic rd(input logic [4:0] a);
        @(negedge clk);
        rb_addr = a; rb_rd = 1;
        @(negedge clk);
        rb_rd = 0;
    endtask

    task automatic pulse(input int i);
        @(negedge clk);
        irq_in[i] = 1;
        @(negedge clk);
        irq_in[i] = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R6: reset values
        tag = "R6";
        rd(5'h00); rd(5'h04); rd(5'h08); rd(5'h0C); rd(5'h10);
        check("R6", "mask_bad after reset", {31'b0, mask_bad}, 32'd0);

        // R7: byte-lane writes and unused offsets
        tag = "R7";
        wr(5'h04, 4'b0001, 32'hFFFF_FF0F);
        rd(5'h04);
        wr(5'h04, 4'b0010, 32'h0000_3300);
        rd(5'h04);
        wr(5'h14, 4'b1111, 32'hDEAD_BEEF);
        rd(5'h14); rd(5'h1C);
        wr(5'h04, 4'b1111, 32'h0000_00FF);

        // R1/R2/R3: masked and unmasked edges
        tag = "R1";
        pulse(10); idle(2);
        rd(5'h08); rd(5'h00);
        tag = "R3";
        ack_delay = 2;
        pulse(3); idle(6);
        tag = "R2";
        rd(5'h00);
        wr(5'h00, 4'b1111, 32'h0);
        rd(5'h00);

        // R5: clear by read, clear by write, collision with a new edge
        tag = "R5";
        pulse(12); idle(1);
        rd(5'h08); rd(5'h08);
        pulse(13); idle(1);
        wr(5'h08, 4'b0000, 32'h0);
        rd(5'h08);
        pulse(14); idle(1);
        @(negedge clk);
        rb_addr = 5'h08; rb_rd = 1; irq_in[15] = 1;
        @(negedge clk);
        rb_rd = 0; irq_in[15] = 0;
        rd(5'h08);
        @(negedge clk);
        rb_addr = 5'h08; rb_wr = 1; rb_be = 4'b1111; irq_in[16] = 1;
        @(negedge clk);
        rb_wr = 0; irq_in[16] = 0;
        rd(5'h08);

        // R4: suppress bit
        tag = "R4";
        wr(5'h0C, 4'b1111, 32'hFFFF_FFFF);
        rd(5'h0C);
        pulse(4); idle(4);
        wr(5'h0C, 4'b1110, 32'h0);
        rd(5'h0C);
        wr(5'h0C, 4'b0001, 32'h0);
        rd(5'h0C);

        // R3: programmed destination
        tag = "R3";
        wr(5'h10, 4'b1111, 32'h1234_5677);
        rd(5'h10);
        ack_delay = 0;
        pulse(5); idle(3);

        // R9: one-deep slot, later edges dropped
        tag = "R9";
        ack_delay = 8;
        pulse(0);
        wr(5'h10, 4'b0001, 32'h0000_0089);
        pulse(1); pulse(2); pulse(6);
        idle(30);
        ack_delay = 1;
        pulse(0); pulse(1); pulse(2); pulse(6); pulse(7);
        idle(12);

        // R10: held input counted once
        tag = "R10";
        @(negedge clk); irq_in[5] = 1;
        idle(3);
        rd(5'h08); idle(4); rd(5'h08);
        @(negedge clk); irq_in[5] = 0;
        idle(4);

        // R8: mask legality flag
        tag = "R8";
        wr(5'h04, 4'b1111, 32'hFFFF_FFFF);
        idle(1);
        check("R8", "all-ones mask is legal", {31'b0, mask_bad}, 32'd0);
        wr(5'h04, 4'b1000, 32'hAB00_0000);
        rd(5'h04);
        wr(5'h04, 4'b1111, 32'h0000_00FF);
        idle(1);
        check("R8", "flag stays set", {31'b0, mask_bad}, 32'd1);
        idle(12);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule